// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of one SDRAM read or write burst. A start strobe supplies the first column, a length code and an ordering flag. From the next cycle onward the block presents one column address per enabled clock, with a valid flag, until the burst ends. A controller uses it to drive the column field of the address bus while the burst is in progress.

Two orderings are provided for the fixed lengths of 2, 4 and 8 beats. In the linear ordering, the low bits count upward and wrap inside the aligned group. In the interleaved ordering, the low bits are the starting bits XORed with the beat number. A page-length burst is also available. It walks every column of the row in order and runs until it is told to stop. It may only be combined with linear ordering. The illegal pairing of page length with interleaved ordering raises an error pulse and starts nothing.

A clock-enable input freezes the whole sequencer while it is low. This lets the burst stretch over stalled cycles.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid`, `burst_done` and `mode_err` are all low.
- R2: A start is accepted on a rising edge where `ce`=1, `start`=1 and no burst is running. Beat 0, carrying `start_col`, is shown in the cycle after that edge. Each later edge with `ce`=1 advances one beat.
- R3: Linear ordering (`interleave`=0) with `bl_sel` 2'b00, 2'b01 or 2'b10 gives lengths 2, 4 and 8. Beat k carries the low 1, 2 or 3 bits equal to (start low bits + k) modulo the length.
- R4: Interleaved ordering (`interleave`=1) with a fixed length gives beat k low bits equal to (start low bits XOR k).
- R5: For fixed lengths, the column bits above the burst field equal those of `start_col` on every beat.
- R6: `burst_done` is high exactly in the cycle showing the last beat of a fixed-length burst. `col_valid` falls after the next edge with `ce`=1.
- R7: `bl_sel`=2'b11 with `interleave`=0 gives a page burst. Beat k is (`start_col` + k) modulo 2^COL_W. `burst_done` never rises, and the burst runs until stopped.
- R8: An edge with `ce`=1 and `stop`=1 during a burst ends it: `col_valid` is low in the next cycle.
- R9: A start with `bl_sel`=2'b11 and `interleave`=1 starts no burst. Instead, `mode_err` is high for the following cycle only (while `ce` stays high).
- R10: While `ce` is low, `col_out`, `col_valid`, `burst_done` and `mode_err` hold their values.
- R11: A `start` arriving while a burst is running is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; low freezes the sequencer |
| start | input | 1 | Request a new burst |
| start_col | input | COL_W | First column of the burst |
| bl_sel | input | 2 | Length code: 00=2, 01=4, 10=8, 11=page |
| interleave | input | 1 | 0 linear ordering, 1 interleaved ordering |
| stop | input | 1 | End the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| burst_done | output | 1 | Current beat is the last of a fixed burst |
| mode_err | output | 1 | Pulse after an illegal length/ordering start |

## Verification
The bench aims at the wrap point of linear bursts started mid-group; a design that carried into the upper bits would show columns outside the aligned group. Interleaved bursts from odd starts are checked, which would expose an adder used in place of the XOR. A page burst is launched two columns below the top of the row, so that a missing modulo wrap or a spurious done is caught. Stalls on a middle beat and on the final beat, a start arriving mid-burst, early stops and the illegal page/interleaved start are also driven; a design that advanced under a low enable, restarted on the new strobe or began a burst on the error would each produce the wrong column or valid sequence.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    BL_TWO   = 2'b00,
    BL_FOUR  = 2'b01,
    BL_EIGHT = 2'b10,
    BL_PAGE  = 2'b11
  } blen_e;
endpackage

// File: rtl/bcs_mode_dec.sv
module bcs_mode_dec
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  blen_e             len,
  input  logic              il,
  output logic [COL_W-1:0]  wrap_mask,
  output logic              is_page,
  output logic              illegal
);
  logic four_up;
  logic eight;

  assign is_page = (len == BL_PAGE);
  assign eight   = (len == BL_EIGHT);
  assign four_up = (len == BL_FOUR) | eight;
  assign illegal = is_page & il;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i == 0) begin : g_b0
      assign wrap_mask[i] = 1'b1;
    end else if (i == 1) begin : g_b1
      assign wrap_mask[i] = four_up | is_page;
    end else if (i == 2) begin : g_b2
      assign wrap_mask[i] = eight | is_page;
    end else begin : g_hi
      assign wrap_mask[i] = is_page;
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              go,
  input  logic              stop,
  input  logic [COL_W-1:0]  last_idx,
  input  logic              page,
  output logic              busy,
  output logic [COL_W-1:0]  beat,
  output logic              last
);
  logic             busy_d;
  logic [COL_W-1:0] beat_d;

  assign last = busy & ~page & (beat == last_idx);

  always_comb begin
    busy_d = busy;
    beat_d = beat;
    if (go) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (busy) begin
      if (stop || last) begin
        busy_d = 1'b0;
      end else begin
        beat_d = beat + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (ce) begin
      busy <= busy_d;
      beat <= beat_d;
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0]  base,
  input  logic [COL_W-1:0]  beat,
  input  logic [COL_W-1:0]  wrap_mask,
  input  logic              il,
  output logic [COL_W-1:0]  col
);
  logic [COL_W-1:0] linear;
  logic [COL_W-1:0] xored;
  logic [COL_W-1:0] offset;

  assign linear = base + beat;
  assign xored  = base ^ beat;
  assign offset = il ? xored : linear;
  assign col    = (base & ~wrap_mask) | (offset & wrap_mask);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [1:0]        bl_sel,
  input  logic              interleave,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              burst_done,
  output logic              mode_err
);
  logic [COL_W-1:0] in_mask;
  logic             in_page;
  logic             in_illegal;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             page_q, page_d;
  logic             il_q, il_d;
  logic [COL_W-1:0] base_q, base_d;
  logic             err_d;
  logic             busy;
  logic [COL_W-1:0] beat;
  logic             accept;
  logic             go;

  bcs_mode_dec #(.COL_W(COL_W)) u_dec (
    .len       (blen_e'(bl_sel)),
    .il        (interleave),
    .wrap_mask (in_mask),
    .is_page   (in_page),
    .illegal   (in_illegal)
  );

  assign accept = start & ~busy;
  assign go     = accept & ~in_illegal;

  always_comb begin
    mask_d = mask_q;
    page_d = page_q;
    il_d   = il_q;
    base_d = base_q;
    err_d  = accept & in_illegal;
    if (go) begin
      mask_d = in_mask;
      page_d = in_page;
      il_d   = interleave;
      base_d = start_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      page_q   <= 1'b0;
      il_q     <= 1'b0;
      base_q   <= '0;
      mode_err <= 1'b0;
    end else if (ce) begin
      mask_q   <= mask_d;
      page_q   <= page_d;
      il_q     <= il_d;
      base_q   <= base_d;
      mode_err <= err_d;
    end
  end

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .go       (go),
    .stop     (stop),
    .last_idx (mask_q),
    .page     (page_q),
    .busy     (busy),
    .beat     (beat),
    .last     (burst_done)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base      (base_q),
    .beat      (beat),
    .wrap_mask (mask_q),
    .il        (il_q),
    .col       (col_out)
  );

  assign col_valid = busy;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             start,
  input logic [1:0]       bl_sel,
  input logic             interleave,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             burst_done,
  input logic             mode_err
);
  // R6
  done_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> col_valid);

  // R6
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && ce) |=> !col_valid);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && ce && stop) |=> !col_valid);

  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && ce && start && bl_sel == 2'b11 && interleave) |=> (mode_err && !col_valid));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(col_out) && $stable(col_valid) && $stable(burst_done) && $stable(mode_err)));

  // R11
  busy_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && ce && !stop && !burst_done) |=> col_valid);

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && ce && start && !(bl_sel == 2'b11 && interleave)) |=> col_valid);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce         (ce),
  .start      (start),
  .bl_sel     (bl_sel),
  .interleave (interleave),
  .stop       (stop),
  .col_out    (col_out),
  .col_valid  (col_valid),
  .burst_done (burst_done),
  .mode_err   (mode_err)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  localparam int COL_W = 9;
  localparam int NVEC  = 8;
  // {bl_sel[1:0], interleave, start_col[8:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 9'h001},
    {2'b00, 1'b1, 9'h0F0},
    {2'b01, 1'b0, 9'h002},
    {2'b01, 1'b0, 9'h1A5},
    {2'b01, 1'b1, 9'h07B},
    {2'b10, 1'b0, 9'h0C6},
    {2'b10, 1'b1, 9'h005},
    {2'b10, 1'b1, 9'h13A}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ce = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       bl_sel = 2'b00;
  logic             interleave = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             burst_done;
  logic             mode_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .start_col(start_col),
    .bl_sel(bl_sel), .interleave(interleave), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .burst_done(burst_done), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int bl, input int il, input int base, input int k);
    int len = 2 << bl;
    int low = base % len;
    int off = il ? (low ^ k) : ((low + k) % len);
    return base - low + off;
  endfunction

  task automatic launch(input logic [1:0] bl, input logic il, input logic [COL_W-1:0] c);
    @(negedge clk);
    start = 1'b1; bl_sel = bl; interleave = il; start_col = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_fixed(input logic [1:0] bl, input logic il, input logic [COL_W-1:0] c);
    int len = 2 << bl;
    launch(bl, il, c);
    for (int k = 0; k < len; k++) begin
      // R3 R4 R5 column per beat
      chk(col_out == COL_W'(exp_col(bl, il, c, k)), il ? "R4/R5 col" : "R3/R5 col",
          col_out, exp_col(bl, il, c, k));
      chk(col_valid == 1'b1, "R2 valid", col_valid, 1);
      chk(burst_done == (k == len - 1), "R6 done", burst_done, k == len - 1);
      if (k < len - 1) @(negedge clk);
    end
    @(negedge clk);
    chk(col_valid == 1'b0, "R6 end", col_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(col_valid == 0 && burst_done == 0 && mode_err == 0, "R1 reset",
        {col_valid, burst_done, mode_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_valid == 0, "R1 idle after release", col_valid, 0);

    for (int v = 0; v < NVEC; v++)
      run_fixed(VEC[v][11:10], VEC[v][9], VEC[v][8:0]);

    // R3 literal: length 4 from 2 -> 2,3,0,1
    launch(2'b01, 1'b0, 9'h002);
    for (int k = 0; k < 4; k++) begin
      chk(col_out == COL_W'((k + 2) % 4), "R3 literal", col_out, (k + 2) % 4);
      @(negedge clk);
    end

    // R10 stall in the middle of a linear 8 burst from 0x0C3
    launch(2'b10, 1'b0, 9'h0C3);
    @(negedge clk);
    ce = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(col_out == 9'h0C4 && col_valid, "R10 hold mid", col_out, 9'h0C4);
    end
    ce = 1'b1;
    @(negedge clk);
    chk(col_out == 9'h0C5, "R10 resume", col_out, 9'h0C5);
    repeat (6) @(negedge clk);
    chk(col_valid == 0, "R6 end after stall", col_valid, 0);

    // R10 stall on the last beat
    launch(2'b00, 1'b0, 9'h010);
    @(negedge clk);
    ce = 1'b0;
    repeat (2) @(negedge clk);
    chk(burst_done && col_valid && col_out == 9'h011, "R10 hold done", burst_done, 1);
    ce = 1'b1;
    @(negedge clk);
    chk(col_valid == 0 && burst_done == 0, "R6 end after hold", col_valid, 0);

    // R7 page burst from 510 with wrap, then R8 stop
    launch(2'b11, 1'b0, 9'd510);
    for (int k = 0; k < 5; k++) begin
      chk(col_out == COL_W'((510 + k) % 512), "R7 page col", col_out, (510 + k) % 512);
      chk(burst_done == 0 && col_valid, "R7 no done", burst_done, 0);
      if (k < 4) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(col_valid == 0, "R8 page stop", col_valid, 0);

    // R8 stop inside a fixed burst
    launch(2'b10, 1'b1, 9'h020);
    chk(col_out == 9'h020, "R4 first", col_out, 9'h020);
    @(negedge clk);
    chk(col_out == 9'h021, "R4 second", col_out, 9'h021);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(col_valid == 0, "R8 fixed stop", col_valid, 0);

    // R9 illegal page + interleaved
    launch(2'b11, 1'b1, 9'h044);
    chk(mode_err == 1 && col_valid == 0, "R9 err pulse", {mode_err, col_valid}, 2);
    @(negedge clk);
    chk(mode_err == 0 && col_valid == 0, "R9 err clears", {mode_err, col_valid}, 0);

    // R11 start during burst ignored
    launch(2'b01, 1'b0, 9'h010);
    start = 1'b1; bl_sel = 2'b10; interleave = 1'b1; start_col = 9'h155;
    @(negedge clk);
    start = 1'b0;
    chk(col_out == 9'h011, "R11 continue", col_out, 9'h011);
    @(negedge clk);
    chk(col_out == 9'h012, "R11 continue2", col_out, 9'h012);
    @(negedge clk);
    chk(col_out == 9'h013 && burst_done, "R11 last", col_out, 9'h013);
    @(negedge clk);
    chk(col_valid == 0, "R11 no restart", col_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule